// File: doc/BRIEF.md
# Exact Binary128 Dot-Product Accumulator

This block computes the inner product of two streams of IEEE-754 binary128 operands with no rounding at any step. Each accepted operand pair is multiplied exactly into a 226-bit significand product. The product is placed by the sum of the two exponents and added, or subtracted when the signs differ, into a fixed-point accumulator. The accumulator is wide enough to hold every partial sum, so the result carries the full value of the sum.

The accumulator is a set of words spread over memory banks. A word's index picks the bank (low index bits) and the row within the bank (high bits). Each product update touches only the few consecutive words its shifted significand overlaps, plus one word above them. Carries between words are not rippled. Each word keeps a signed pending-carry field that is folded in the next time that word is updated. A drain command walks every word from least to most significant and resolves all pending carries, so that the words read back as one two's-complement number.

A clear pulse empties the accumulator before a new dot product starts. Operand pairs arrive with a valid strobe, one per cycle at most, and back-to-back pairs may hit the same words. Results are read one word at a time through an index port once the drain has finished.

Top module: `dotacc_exact`

## Requirements
- R1: After reset, and in the cycle after `clear`, `busy` is low, every operand still in the pipeline is dropped, and every accumulator word reads as zero.
- R2: Operands are laid out as {sign, exponent[EXP_W-1:0], fraction[FRAC_W-1:0]} from MSB to LSB. Each accepted pair adds S_a*S_b*2^(E_a+E_b-2) to the accumulator. Here S = {exponent != 0, fraction}, E = exponent when it is nonzero and 1 when it is zero, and bit 0 of word 0 has weight 1.
- R3: When the two sign bits differ, the product is subtracted. The drained words then form the two's-complement sum modulo 2^(NW*WORD_W).
- R4: Pairs accepted on consecutive cycles are all summed exactly, including runs where each pair hits the same words as the one before.
- R5: A pair in which either operand has exponent and fraction both zero leaves the accumulator unchanged, whatever its sign bits.
- R6: A `drain` pulse while idle raises `busy` in the next cycle. `busy` stays high until every word is resolved. Operand pairs presented while `busy` is high are ignored.
- R7: `rd_word` shows accumulator word `rd_idx` one cycle after `rd_idx` is set. Word 0 is the least significant.
- R8: The pending-carry field of every word stays within its signed CARRY_W-bit range for up to 2^(CARRY_W-3) accepted pairs between clear and drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Empty the accumulator and the pipeline |
| in_valid | input | 1 | Operand pair valid |
| in_a | input | 1+EXP_W+FRAC_W | First operand |
| in_b | input | 1+EXP_W+FRAC_W | Second operand |
| drain | input | 1 | Start resolving the pending carries |
| busy | output | 1 | Drain in progress |
| rd_idx | input | IW | Word index for read-out |
| rd_word | output | WORD_W | Accumulator word, one cycle after the index |

## Verification
The bench builds the block with EXP_W=3, FRAC_W=2, WORD_W=4, NBANKS=4 and CARRY_W=12. That gives 64 operand codes, so every one of the 4096 pairs, including all zero and subnormal codes, is swept as a single-term product. The accumulator is eight 4-bit words across four banks, so each product straddles several words and the span wraps around the banks. Multi-term runs of up to 300 back-to-back pairs exercise forwarding between neighbouring updates and the growth of the pending carries. All results are compared as plain 32-bit integers.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;
  typedef enum logic [1:0] {
    PH_ACC   = 2'd0,
    PH_DRAIN = 2'd1,
    PH_FLUSH = 2'd2
  } phase_t;
endpackage

// File: rtl/dotacc_align.sv
module dotacc_align #(
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 112,
  parameter int WORD_W = 64,
  parameter int SPAN   = 5,
  parameter int IW     = 11
) (
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  output logic                      term_live,
  output logic                      term_neg,
  output logic [IW-1:0]             term_lo,
  output logic [SPAN*WORD_W-1:0]    term_bits
);
  localparam int OP_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam int PW    = 2 * SIG_W;
  localparam int LW    = $clog2(WORD_W);
  localparam int SHW   = EXP_W + 1;

  // significand with the hidden bit restored (zero for subnormals)
  function automatic logic [SIG_W-1:0] sig_of(input logic [OP_W-1:0] v);
    return {|v[OP_W-2:FRAC_W], v[FRAC_W-1:0]};
  endfunction

  // effective biased exponent: subnormals share the smallest normal scale
  function automatic logic [EXP_W-1:0] scale_of(input logic [OP_W-1:0] v);
    logic [EXP_W-1:0] e;
    e = v[OP_W-2:FRAC_W];
    return (e == '0) ? EXP_W'(1) : e;
  endfunction

  function automatic logic is_void(input logic [OP_W-1:0] v);
    return v[OP_W-2:0] == '0;
  endfunction

  // bit position of the product LSB inside the accumulator
  function automatic logic [SHW-1:0] place(input logic [EXP_W-1:0] ea,
                                           input logic [EXP_W-1:0] eb);
    return {1'b0, ea} + {1'b0, eb} - SHW'(2);
  endfunction

  logic [PW-1:0]  prod;
  logic [SHW-1:0] sh;
  logic [LW-1:0]  off;

  always_comb begin
    prod      = PW'(sig_of(op_a)) * PW'(sig_of(op_b));
    sh        = place(scale_of(op_a), scale_of(op_b));
    off       = sh[LW-1:0];
    term_lo   = IW'(sh >> LW);
    term_bits = (SPAN*WORD_W)'(prod) << off;
    term_neg  = op_a[OP_W-1] ^ op_b[OP_W-1];
    term_live = !is_void(op_a) && !is_void(op_b);
  end
endmodule

// File: rtl/dotacc_bank.sv
module dotacc_bank #(
  parameter int ROWS    = 129,
  parameter int RW      = 8,
  parameter int WORD_W  = 64,
  parameter int CARRY_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic [RW-1:0]             rd_row,
  output logic [WORD_W-1:0]         rd_dat,
  output logic signed [CARRY_W-1:0] rd_cy,
  input  logic                      wr_en,
  input  logic [RW-1:0]             wr_row,
  input  logic [WORD_W-1:0]         wr_dat,
  input  logic signed [CARRY_W-1:0] wr_cy,
  input  logic [RW-1:0]             ro_row,
  output logic [WORD_W-1:0]         ro_dat
);
  logic [WORD_W-1:0]         dmem [ROWS];
  logic signed [CARRY_W-1:0] cmem [ROWS];
  logic                      fwd_hit;
  logic                      rd_in, ro_in;

  assign fwd_hit = wr_en && (wr_row == rd_row);
  assign rd_in   = 32'(rd_row) < ROWS;
  assign ro_in   = 32'(ro_row) < ROWS;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int r = 0; r < ROWS; r++) begin
        dmem[r] <= '0;
        cmem[r] <= '0;
      end
      rd_dat <= '0;
      rd_cy  <= '0;
      ro_dat <= '0;
    end else begin
      if (wr_en) begin
        dmem[wr_row] <= wr_dat;
        cmem[wr_row] <= wr_cy;
      end
      if (fwd_hit) begin
        rd_dat <= wr_dat;
        rd_cy  <= wr_cy;
      end else begin
        rd_dat <= rd_in ? dmem[rd_row] : '0;
        rd_cy  <= rd_in ? cmem[rd_row] : '0;
      end
      ro_dat <= ro_in ? dmem[ro_row] : '0;
    end
  end

  // R4: a row written while it is read must reach the reader with the new value
  assert_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_hit && !clr) |=> (rd_dat == $past(wr_dat) && rd_cy == $past(wr_cy)));
endmodule

// File: rtl/dotacc_update.sv
module dotacc_update #(
  parameter int WORD_W  = 64,
  parameter int CARRY_W = 16,
  parameter int SPAN    = 5,
  parameter int NBANKS  = 8,
  parameter int LNB     = 3
) (
  input  logic                        op_drain,
  input  logic                        op_neg,
  input  logic [LNB-1:0]              op_lomod,
  input  logic signed [CARRY_W-1:0]   run_in,
  input  logic [SPAN*WORD_W-1:0]      op_bits,
  input  logic [NBANKS*WORD_W-1:0]    rd_dat_flat,
  input  logic [NBANKS*CARRY_W-1:0]   rd_cy_flat,
  output logic [NBANKS-1:0]           wr_mask,
  output logic [NBANKS*WORD_W-1:0]    wr_dat_flat,
  output logic [NBANKS*CARRY_W-1:0]   wr_cy_flat,
  output logic signed [CARRY_W-1:0]   run_out,
  output logic                        cy_ovf
);
  localparam int SUMW = WORD_W + CARRY_W + 2;

  function automatic logic signed [SUMW-1:0] ext_u(input logic [WORD_W-1:0] v);
    return $signed({{(SUMW-WORD_W){1'b0}}, v});
  endfunction

  function automatic logic signed [SUMW-1:0] ext_s(input logic [CARRY_W-1:0] v);
    return $signed({{(SUMW-CARRY_W){v[CARRY_W-1]}}, v});
  endfunction

  function automatic logic fits(input logic signed [SUMW-1:0] v);
    return v == ext_s(v[CARRY_W-1:0]);
  endfunction

  logic signed [SUMW-1:0] acc, carry, grow, addend;
  logic [LNB-1:0]         bk;
  logic [WORD_W-1:0]      chunk;

  always_comb begin
    wr_mask     = '0;
    wr_dat_flat = rd_dat_flat;
    wr_cy_flat  = rd_cy_flat;
    run_out     = run_in;
    cy_ovf      = 1'b0;
    carry       = '0;
    acc         = '0;
    grow        = '0;
    addend      = '0;
    bk          = op_lomod;
    chunk       = '0;
    for (int k = 0; k < SPAN; k++) begin
      if (!op_drain || k == 0) begin
        bk     = op_lomod + LNB'(k);
        chunk  = op_drain ? '0 : op_bits[k*WORD_W +: WORD_W];
        addend = op_neg ? -ext_u(chunk) : ext_u(chunk);
        acc    = ext_u(rd_dat_flat[bk*WORD_W +: WORD_W])
               + ext_s(rd_cy_flat[bk*CARRY_W +: CARRY_W])
               + ((op_drain && k == 0) ? ext_s(run_in) : '0)
               + addend;
        wr_dat_flat[bk*WORD_W +: WORD_W] = acc[WORD_W-1:0];
        if (k == 0) begin
          wr_cy_flat[bk*CARRY_W +: CARRY_W] = '0;
        end else begin
          wr_cy_flat[bk*CARRY_W +: CARRY_W] = carry[CARRY_W-1:0];
          if (!fits(carry)) cy_ovf = 1'b1;
        end
        carry       = acc >>> WORD_W;
        wr_mask[bk] = 1'b1;
        if (op_drain) run_out = carry[CARRY_W-1:0];
      end
    end
    if (!op_drain) begin
      bk   = op_lomod + LNB'(SPAN);
      grow = ext_s(rd_cy_flat[bk*CARRY_W +: CARRY_W]) + carry;
      wr_cy_flat[bk*CARRY_W +: CARRY_W] = grow[CARRY_W-1:0];
      if (!fits(grow)) cy_ovf = 1'b1;
      wr_mask[bk] = 1'b1;
    end
  end
endmodule

// File: rtl/dotacc_exact.sv
module dotacc_exact #(
  parameter int EXP_W   = 15,
  parameter int FRAC_W  = 112,
  parameter int WORD_W  = 64,
  parameter int NBANKS  = 8,
  parameter int CARRY_W = 16,
  localparam int OP_W      = 1 + EXP_W + FRAC_W,
  localparam int PW        = 2 * (FRAC_W + 1),
  localparam int SHIFT_MAX = 2 * ((1 << EXP_W) - 1) - 2,
  localparam int SPAN      = (PW + WORD_W - 2) / WORD_W + 1,
  localparam int NW_MIN    = SHIFT_MAX / WORD_W + SPAN + 2,
  localparam int ROWS      = (NW_MIN + NBANKS - 1) / NBANKS,
  localparam int NW        = ROWS * NBANKS,
  localparam int IW        = $clog2(NW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_a,
  input  logic [OP_W-1:0]   in_b,
  input  logic              drain,
  output logic              busy,
  input  logic [IW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  import dotacc_pkg::*;

  localparam int LNB = $clog2(NBANKS);
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int BW  = SPAN * WORD_W;

  phase_t                    phase;
  logic [IW-1:0]             dcount;
  logic signed [CARRY_W-1:0] run, run_next;

  logic          t_live, t_neg;
  logic [IW-1:0] t_lo;
  logic [BW-1:0] t_bits;

  logic          a_valid, a_drain, a_neg;
  logic [IW-1:0] a_lo;
  logic [BW-1:0] a_bits;
  logic          c_valid, c_drain, c_neg;
  logic [IW-1:0] c_lo;
  logic [BW-1:0] c_bits;

  logic term_accept, drain_inject;

  logic [NBANKS*WORD_W-1:0]  rd_dat_flat, wr_dat_flat;
  logic [NBANKS*CARRY_W-1:0] rd_cy_flat, wr_cy_flat;
  logic [NBANKS-1:0]         wr_mask;
  logic                      cy_ovf;
  logic [RW-1:0]             ro_row;
  logic [LNB-1:0]            ro_sel_q;
  logic [WORD_W-1:0]         ro_dat [NBANKS];

  dotacc_align #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .WORD_W(WORD_W), .SPAN(SPAN), .IW(IW)
  ) u_align (
    .op_a(in_a), .op_b(in_b), .term_live(t_live), .term_neg(t_neg),
    .term_lo(t_lo), .term_bits(t_bits)
  );

  assign term_accept  = (phase == PH_ACC) && in_valid && t_live;
  assign drain_inject = (phase == PH_DRAIN);
  assign busy         = (phase != PH_ACC);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      phase   <= PH_ACC;
      dcount  <= '0;
      run     <= '0;
      a_valid <= 1'b0;
      a_drain <= 1'b0;
      a_neg   <= 1'b0;
      a_lo    <= '0;
      a_bits  <= '0;
      c_valid <= 1'b0;
      c_drain <= 1'b0;
      c_neg   <= 1'b0;
      c_lo    <= '0;
      c_bits  <= '0;
    end else begin
      a_valid <= term_accept || drain_inject;
      a_drain <= drain_inject;
      a_neg   <= t_neg;
      a_lo    <= drain_inject ? dcount : t_lo;
      a_bits  <= t_bits;
      c_valid <= a_valid;
      c_drain <= a_drain;
      c_neg   <= a_neg;
      c_lo    <= a_lo;
      c_bits  <= a_bits;
      if (c_valid && c_drain) run <= run_next;
      unique case (phase)
        PH_ACC: if (drain) begin
          phase  <= PH_DRAIN;
          dcount <= '0;
          run    <= '0;
        end
        PH_DRAIN: begin
          dcount <= dcount + IW'(1);
          if (dcount == IW'(NW - 1)) phase <= PH_FLUSH;
        end
        PH_FLUSH: if (!a_valid && !c_valid) phase <= PH_ACC;
        default: phase <= PH_ACC;
      endcase
    end
  end

  dotacc_update #(
    .WORD_W(WORD_W), .CARRY_W(CARRY_W), .SPAN(SPAN), .NBANKS(NBANKS), .LNB(LNB)
  ) u_update (
    .op_drain(c_drain), .op_neg(c_neg), .op_lomod(c_lo[LNB-1:0]), .run_in(run),
    .op_bits(c_bits), .rd_dat_flat(rd_dat_flat), .rd_cy_flat(rd_cy_flat),
    .wr_mask(wr_mask), .wr_dat_flat(wr_dat_flat), .wr_cy_flat(wr_cy_flat),
    .run_out(run_next), .cy_ovf(cy_ovf)
  );

  assign ro_row = RW'(rd_idx >> LNB);

  always_ff @(posedge clk) begin
    if (!rst_n) ro_sel_q <= '0;
    else        ro_sel_q <= rd_idx[LNB-1:0];
  end

  assign rd_word = ro_dat[ro_sel_q];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [LNB-1:0] ka, kc;
    logic [IW-1:0]  ia, ic;
    logic [RW-1:0]  rrow, wrow;
    assign ka   = LNB'(b) - a_lo[LNB-1:0];
    assign kc   = LNB'(b) - c_lo[LNB-1:0];
    assign ia   = a_lo + IW'(ka);
    assign ic   = c_lo + IW'(kc);
    assign rrow = RW'(ia >> LNB);
    assign wrow = RW'(ic >> LNB);
    dotacc_bank #(
      .ROWS(ROWS), .RW(RW), .WORD_W(WORD_W), .CARRY_W(CARRY_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(clear),
      .rd_row(rrow),
      .rd_dat(rd_dat_flat[b*WORD_W +: WORD_W]),
      .rd_cy(rd_cy_flat[b*CARRY_W +: CARRY_W]),
      .wr_en(c_valid && wr_mask[b]),
      .wr_row(wrow),
      .wr_dat(wr_dat_flat[b*WORD_W +: WORD_W]),
      .wr_cy(wr_cy_flat[b*CARRY_W +: CARRY_W]),
      .ro_row(ro_row),
      .ro_dat(ro_dat[b])
    );
  end

  // R1: clear empties the pipeline and leaves the block idle
  assert_clear_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!busy && !a_valid && !c_valid));

  // R5: an operand with zero exponent and fraction never enters the pipeline
  assert_skip_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clear && phase == PH_ACC && in_a[OP_W-2:0] == '0) |=> !a_valid);

  // R6: a drain request raises busy on the next cycle
  assert_busy_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !busy && !clear) |=> busy);

  // R6: while draining, no accumulation update is admitted
  assert_ignore_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clear) |=> !(a_valid && !a_drain));

  // R8: pending carries never leave their signed field range
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> !cy_ovf);
endmodule

// File: tb/sim_dotacc_exact.sv
module sim_dotacc_exact;
  localparam int EW = 3, FW = 2, WW = 4, NB = 4, CW = 12;
  localparam int NW = 8, IW = 3, OPW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n, clear, in_valid, drain, busy;
  logic [OPW-1:0] in_a, in_b;
  logic [IW-1:0]  rd_idx;
  logic [WW-1:0]  rd_word;
  int checks = 0, errors = 0;

  dotacc_exact #(.EXP_W(EW), .FRAC_W(FW), .WORD_W(WW), .NBANKS(NB), .CARRY_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid), .in_a(in_a),
    .in_b(in_b), .drain(drain), .busy(busy), .rd_idx(rd_idx), .rd_word(rd_word)
  );

  // value of one pair: layout {sign, exp[2:0], frac[1:0]}
  function automatic longint term(input logic [5:0] a, input logic [5:0] b);
    longint sa, sb, ea, eb, mag;
    sa  = ((a[4:2] != 0) ? 4 : 0) + a[1:0];
    sb  = ((b[4:2] != 0) ? 4 : 0) + b[1:0];
    ea  = (a[4:2] == 0) ? 1 : a[4:2];
    eb  = (b[4:2] == 0) ? 1 : b[4:2];
    mag = (sa * sb) << (ea + eb - 2);
    return (a[5] ^ b[5]) ? -mag : mag;
  endfunction

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic read_all(output logic [31:0] v);
    for (int i = 0; i < NW; i++) begin
      rd_idx = IW'(i);
      @(negedge clk);
      v[i*WW +: WW] = rd_word;
    end
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic push(input logic [5:0] a, input logic [5:0] b);
    in_valid = 1'b1; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_drain();
    drain = 1'b1;
    @(negedge clk);
    drain = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic check_sum(input string tag, input longint exp);
    logic [31:0] v;
    run_drain();
    read_all(v);
    chk(tag, longint'(v), longint'(exp[31:0]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [15:0] lf;
    longint      exp;
    logic [5:0]  pa, pb;
    rst_n = 1'b0; clear = 1'b0; in_valid = 1'b0; drain = 1'b0;
    in_a = '0; in_b = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy after reset", longint'(busy), 0);
    read_all(v);
    chk("R1 words after reset", longint'(v), 0);

    // R7: 4*4 at scale 5+5-2=8 gives 2^12, so word 3 holds 1
    push(6'b0_101_00, 6'b0_101_00);
    run_drain();
    rd_idx = 3'd3; @(negedge clk);
    chk("R7 word3", longint'(rd_word), 1);
    rd_idx = 3'd0; @(negedge clk);
    chk("R7 word0", longint'(rd_word), 0);

    // R2 / R3 / R5: every single pair
    for (int ai = 0; ai < 64; ai++) begin
      for (int bi = 0; bi < 64; bi++) begin
        pa = 6'(ai); pb = 6'(bi);
        do_clear();
        push(pa, pb);
        if (pa[4:0] == 0 || pb[4:0] == 0) check_sum("R5 zero operand", 0);
        else if (pa[5] ^ pb[5])           check_sum("R3 negative pair", term(pa, pb));
        else                              check_sum("R2 positive pair", term(pa, pb));
      end
    end

    // R4: long back-to-back runs of mixed pairs
    lf = 16'hACE1;
    for (int s = 0; s < 3; s++) begin
      do_clear();
      exp = 0;
      for (int n = 0; n < 300; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        pa = lf[5:0]; pb = lf[11:6];
        exp += term(pa, pb);
        in_valid = 1'b1; in_a = pa; in_b = pb;
        @(negedge clk);
      end
      in_valid = 1'b0;
      check_sum("R4 mixed run", exp);
    end

    // R8: same words hit 200 times in a row, pending carries pile up
    do_clear();
    for (int n = 0; n < 200; n++) begin
      in_valid = 1'b1; in_a = 6'b0_111_11; in_b = 6'b0_110_11;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check_sum("R8 repeated pair", 200 * term(6'b0_111_11, 6'b0_110_11));

    // R3 / R4: alternating signs that cancel to a small remainder
    do_clear();
    for (int n = 0; n < 100; n++) begin
      in_valid = 1'b1; in_a = (n % 2 == 0) ? 6'b0_111_10 : 6'b1_111_10; in_b = 6'b0_111_01;
      @(negedge clk);
    end
    in_valid = 1'b1; in_a = 6'b1_001_01; in_b = 6'b0_001_00;
    @(negedge clk);
    in_valid = 1'b0;
    check_sum("R3 cancelling run", term(6'b1_001_01, 6'b0_001_00));

    // R5: zeros mixed into a running sum change nothing
    do_clear();
    push(6'b0_100_01, 6'b0_011_10);
    push(6'b1_000_00, 6'b0_111_11);
    push(6'b0_110_11, 6'b0_000_00);
    check_sum("R5 zeros in sum", term(6'b0_100_01, 6'b0_011_10));

    // R6: busy rises after drain, inputs during busy are ignored
    do_clear();
    push(6'b0_011_01, 6'b0_010_11);
    drain = 1'b1;
    @(negedge clk);
    drain = 1'b0;
    chk("R6 busy after drain", longint'(busy), 1);
    for (int n = 0; n < 4; n++) begin
      in_valid = 1'b1; in_a = 6'b0_111_11; in_b = 6'b0_111_11;
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (busy) @(negedge clk);
    read_all(v);
    chk("R6 ignored inputs", longint'(v), term(6'b0_011_01, 6'b0_010_11));

    // R1: clear drops a sum and an operand still in flight
    do_clear();
    push(6'b0_111_11, 6'b0_111_11);
    push(6'b0_101_11, 6'b1_110_01);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    push(6'b1_010_10, 6'b0_011_00);
    check_sum("R1 clear in flight", term(6'b1_010_10, 6'b0_011_00));
    do_clear();
    check_sum("R1 clear empties", 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule